// File: doc/BRIEF.md
# Folding Modular Residue Unit

This combinational unit reduces a sign-and-magnitude binary operand modulo m, where m is either 2^K-1 or 2^K+1. A parameter selects which of the two. The operand magnitude is cut into K-bit groups, starting at the least significant bit. In the 2^K-1 mode the groups are summed. In the 2^K+1 mode they are summed with alternating signs, with the lowest group added. Each fold gives a shorter partial result that carries its own sign, and the fold is repeated until only K+1 bits remain.

A final step then merges the K low bits with the overflow bit. It adds that bit in the 2^K-1 mode and subtracts it in the 2^K+1 mode. It then decodes the zero condition and maps a negative partial value to its positive residue. No divider and no lookup table are used.

The unit is used wherever a residue-number datapath has to turn a plain binary word into a residue digit. Several instances with different K and modes can each produce one digit of a residue vector from the same operand.

Top module: `fold_residue`

## Requirements
- R1: With PLUS=0 and neg_i=0, res_o equals mag_i mod (2^K-1) for every magnitude.
- R2: With PLUS=1 and neg_i=0, res_o equals mag_i mod (2^K+1) for every magnitude.
- R3: With neg_i=1, res_o equals (-mag_i) mod m. This is 0 when mag_i is a multiple of m, and m minus (mag_i mod m) otherwise.
- R4: When mag_i is a nonzero multiple of m, including m itself, res_o is 0 for either sign (zero condition).
- R5: res_o is always below m. It is K bits wide for PLUS=0 and K+1 bits wide for PLUS=1, so that 2^K can be represented.
- R6: A zero magnitude gives res_o = 0 whether neg_i is 0 or 1.
- R7: Operands whose groups are all at their maximum, or alternate between maximum and zero, still give the correct residue. Examples are all ones, 0xAAAA, 0x5555 and 0x8000; the overflow of every fold is absorbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mag_i | input | N | Operand magnitude, unsigned |
| neg_i | input | 1 | Operand sign, 1 = negative |
| res_o | output | RW (K for PLUS=0, K+1 for PLUS=1) | Residue of the signed operand, range 0 to m-1 |

## Verification
The block holds no state. A wrong internal value appears at res_o in the same evaluation as the operand that triggers it, for example a dropped overflow bit, a sign lost between folds or a missed zero decode. Such a fault only shows for operands that reach the faulty path. For that reason every 16-bit magnitude is applied with both signs to one instance in each mode. The runs of maximum groups, the exact multiples of m and the zero operand are then revisited as named scenarios.

// File: rtl/fold_residue_pkg.sv
package fold_residue_pkg;

  // width of the partial result after one fold of a w-bit magnitude
  function automatic int fold_width(input int w, input int k);
    int g;
    g = (w + k - 1) / k;
    return $clog2(g) + k;
  endfunction

  // input width of fold stage i (stage 0 sees the operand)
  function automatic int stage_w(input int n, input int k, input int i);
    int w;
    w = n;
    for (int j = 0; j < i; j++) w = fold_width(w, k);
    return w;
  endfunction

  // number of folds until the width is at most k+1
  function automatic int num_folds(input int n, input int k);
    int w;
    int c;
    w = n;
    c = 0;
    for (int j = 0; j < 64; j++) begin
      if (w > k + 1) begin
        w = fold_width(w, k);
        c++;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/fold_stage.sv
module fold_stage #(
  parameter int K     = 2,
  parameter bit PLUS  = 1'b1,
  parameter int IN_W  = 16,
  parameter int OUT_W = 5
) (
  input  logic             sign_i,
  input  logic [IN_W-1:0]  mag_i,
  output logic             sign_o,
  output logic [OUT_W-1:0] mag_o
);

  localparam int G  = (IN_W + K - 1) / K;
  localparam int PW = G * K;
  localparam int AW = OUT_W + 1;
  localparam longint M = PLUS ? (longint'(1) << K) + 1 : (longint'(1) << K) - 1;

  logic [PW-1:0]        pad;
  logic signed [AW-1:0] acc;
  logic                 neg;

  assign pad = PW'(mag_i);

  // odd groups are subtracted in the 2^K+1 mode
  always_comb begin
    acc = '0;
    for (int g = 0; g < G; g++) begin
      if (PLUS && (g % 2) == 1) acc = acc - $signed(AW'(pad[g*K +: K]));
      else                      acc = acc + $signed(AW'(pad[g*K +: K]));
    end
  end

  assign neg    = acc[AW-1];
  assign mag_o  = OUT_W'(neg ? -acc : acc);
  assign sign_o = sign_i ^ neg;

  always_comb begin : cong_blk
    longint vi;
    longint vo;
    vi = longint'(mag_i);
    vo = longint'(mag_o);
    if (sign_i) vi = -vi;
    if (sign_o) vo = -vo;
    // R1, R2
    fold_congruent_chk: assert (((vi % M) + M) % M == ((vo % M) + M) % M);
  end

endmodule

// File: rtl/fold_fix.sv
module fold_fix #(
  parameter int K    = 2,
  parameter bit PLUS = 1'b1,
  localparam int RW  = PLUS ? K + 1 : K
) (
  input  logic          sign_i,
  input  logic [K:0]    mag_i,
  output logic [RW-1:0] res_o
);

  localparam int W = K + 1;
  localparam logic [W-1:0] M = PLUS ? W'((1 << K) + 1) : W'((1 << K) - 1);

  logic [W-1:0] mag;
  logic         neg;
  logic         zero;
  logic [W-1:0] full;

  if (PLUS) begin : g_plus
    logic signed [W:0] d;
    assign d   = $signed((W+1)'(mag_i[K-1:0])) - $signed((W+1)'(mag_i[K]));
    assign neg = sign_i ^ d[W];
    assign mag = W'(d[W] ? -d : d);
  end else begin : g_minus
    logic [W-1:0] s1;
    logic [W-1:0] s2;
    // end-around carry, applied twice so 2^K wraps to 1
    assign s1  = W'(mag_i[K-1:0]) + W'(mag_i[K]);
    assign s2  = W'(s1[K-1:0]) + W'(s1[K]);
    assign mag = s2;
    assign neg = sign_i;
  end

  assign zero  = (mag == '0) || (mag == M);
  assign full  = zero ? '0 : (neg ? M - mag : mag);
  assign res_o = RW'(full);

  always_comb begin
    // R4
    absorb_range_chk: assert (mag <= M);
  end

endmodule

// File: rtl/fold_residue.sv
module fold_residue
  import fold_residue_pkg::*;
#(
  parameter int N    = 16,
  parameter int K    = 2,
  parameter bit PLUS = 1'b1,
  localparam int RW  = PLUS ? K + 1 : K
) (
  input  logic [N-1:0]  mag_i,
  input  logic          neg_i,
  output logic [RW-1:0] res_o
);

  localparam int NS = num_folds(N, K);
  localparam int M  = PLUS ? (1 << K) + 1 : (1 << K) - 1;

  for (genvar i = 0; i < NS; i++) begin : g_fold
    localparam int IW = stage_w(N, K, i);
    localparam int OW = stage_w(N, K, i + 1);
    logic          si;
    logic [IW-1:0] mi;
    logic          s;
    logic [OW-1:0] m;
    if (i == 0) begin : g_first
      assign si = neg_i;
      assign mi = mag_i;
    end else begin : g_next
      assign si = g_fold[i-1].s;
      assign mi = g_fold[i-1].m;
    end
    fold_stage #(.K(K), .PLUS(PLUS), .IN_W(IW), .OUT_W(OW)) u_fold (
      .sign_i(si), .mag_i(mi), .sign_o(s), .mag_o(m)
    );
  end

  logic       fs;
  logic [K:0] fm;

  if (NS == 0) begin : g_direct
    assign fs = neg_i;
    assign fm = (K+1)'(mag_i);
  end else begin : g_tail
    assign fs = g_fold[NS-1].s;
    assign fm = (K+1)'(g_fold[NS-1].m);
  end

  fold_fix #(.K(K), .PLUS(PLUS)) u_fix (
    .sign_i(fs), .mag_i(fm), .res_o(res_o)
  );

  always_comb begin
    // R5
    res_range_chk: assert (int'(res_o) < M);
    // R6
    zero_in_chk: assert (mag_i != '0 || res_o == '0);
  end

endmodule

// File: tb/fold_residue_tb.sv
module fold_residue_tb_top;

  logic        clk;
  logic        rst_ni;
  logic [15:0] mag;
  logic        neg;
  logic [2:0]  res_p;
  logic [2:0]  res_m;
  int          n_vec;
  int          n_bad;

  localparam int MP = 5;
  localparam int MM = 7;
  localparam int WD_LIMIT = 190000;

  // 2^2+1 = 5
  fold_residue #(.N(16), .K(2), .PLUS(1'b1)) dut_i (
    .mag_i(mag), .neg_i(neg), .res_o(res_p)
  );
  // 2^3-1 = 7
  fold_residue #(.N(16), .K(3), .PLUS(1'b0)) dut_m_i (
    .mag_i(mag), .neg_i(neg), .res_o(res_m)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_res(input int m, input logic [15:0] mg, input logic ng);
    int v;
    v = int'(mg) % m;
    if (ng && v != 0) v = m - v;
    return v;
  endfunction

  task automatic cmp(input string tag, input int got, input int exp, input string which);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s mag=%0d neg=%0d got %0d exp %0d", tag, which, mag, neg, got, exp);
    end
  endtask

  task automatic drive_check(input logic [15:0] mg, input logic ng, input string tag);
    @(negedge clk);
    mag = mg;
    neg = ng;
    @(posedge clk);
    #1;
    cmp(tag, int'(res_p), exp_res(MP, mg, ng), "mod5");
    cmp(tag, int'(res_m), exp_res(MM, mg, ng), "mod7");
  endtask

  task automatic t_reset;
    @(posedge clk);
    #1;
    cmp("R6", int'(res_p), 0, "mod5 reset");
    cmp("R6", int'(res_m), 0, "mod7 reset");
  endtask

  task automatic t_zero;
    drive_check(16'd0, 1'b0, "R6");
    drive_check(16'd0, 1'b1, "R6");
  endtask

  task automatic t_sweep_pos;
    for (int v = 0; v < 65536; v++) drive_check(16'(v), 1'b0, "R1,R2");
  endtask

  task automatic t_sweep_neg;
    for (int v = 0; v < 65536; v++) drive_check(16'(v), 1'b1, "R3");
  endtask

  task automatic t_zero_cond;
    for (int j = 1; j <= 24; j++) begin
      drive_check(16'(MP * j), 1'b0, "R4");
      drive_check(16'(MP * j), 1'b1, "R4");
      drive_check(16'(MM * j), 1'b0, "R4");
      drive_check(16'(MM * j), 1'b1, "R4");
    end
    drive_check(16'd65535, 1'b1, "R4");
    drive_check(16'd65534, 1'b0, "R4");
  endtask

  task automatic t_extremes;
    logic [15:0] pat [8];
    pat = '{16'hFFFF, 16'hFFFE, 16'h8000, 16'hAAAA,
            16'h5555, 16'h7FFF, 16'hCCCC, 16'h3333};
    for (int i = 0; i < 8; i++) begin
      drive_check(pat[i], 1'b0, "R7");
      drive_check(pat[i], 1'b1, "R7");
    end
  endtask

  task automatic t_range;
    for (int v = 65500; v < 65536; v++) begin
      drive_check(16'(v), v[0], "R5");
      cmp("R5", int'(res_p < 3'(MP)), 1, "mod5 range");
      cmp("R5", int'(res_m < 3'(MM)), 1, "mod7 range");
    end
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= WD_LIMIT) begin
        n_bad++;
        $display("FAIL R1 watchdog: got %0d cycles exp < %0d", cyc, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_vec  = 0;
    n_bad  = 0;
    mag    = '0;
    neg    = 1'b0;
    rst_ni = 1'b0;
    t_reset();
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_zero();
    t_zero_cond();
    t_extremes();
    t_range();
    t_sweep_pos();
    t_sweep_neg();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule